// File: doc/BRIEF.md
# DMA Completion Response Queue

This block sits between a DMA engine and the software-visible register space. Each time the engine finishes a descriptor it hands over one completion record: the number of bytes moved, an eight-bit error code and a flag that marks a transfer which ended before its programmed length. The queue holds these records in arrival order until software collects them.

Software sees the head record through a two-word read window. Word 0 returns the byte count and can be read any number of times without disturbing the queue. Word 1 returns the status word and removes the head record in the same access, so software reads word 0 first and then word 1 to retire one completion. The queue also drives a 16-bit fill level and empty and full flags toward the control and status logic.

The engine pushes through a valid/ready handshake. Ready is low while the queue is full, so a completion is never lost. Read data is registered and appears on the cycle after the read strobe.

Top module: `dma_rsp_queue`

## Requirements
- R1: After reset the fill level is 0, the empty flag is 1, the full flag is 0, push ready is 1 and the read data is 0.
- R2: A push (push_valid high while push_ready is high at a clock edge) stores one record and raises the fill level by one from the next cycle.
- R3: A read with rd_word = 0 returns the head record's byte count on rd_data in the next cycle and leaves the fill level and the head unchanged.
- R4: A read with rd_word = 1 returns the head record's status word in the next cycle: bits 7:0 are the error code, bit 8 is the early-end flag and bits 31:9 are zero. The same read removes the head record.
- R5: Records leave the queue in the order they were pushed.
- R6: A read of either word while the queue is empty returns 0 and leaves the fill level unchanged.
- R7: While the queue holds DEPTH records push_ready is low, and a push attempt stores nothing and leaves the fill level at DEPTH.
- R8: A push and a status-word read in the same cycle on a non-empty queue both take effect and leave the fill level unchanged.
- R9: fill_level is the 16-bit count of stored records; the empty flag is 1 exactly when it is 0 and the full flag is 1 exactly when it equals DEPTH.
- R10: rd_data holds its last value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Engine offers a completion record |
| push_ready | output | 1 | Queue can take a record this cycle |
| push_bytes | input | 32 | Bytes moved by the finished descriptor |
| push_err | input | 8 | Error code of the finished descriptor |
| push_early | input | 1 | Descriptor ended before its programmed length |
| rd_en | input | 1 | Software read strobe |
| rd_word | input | 1 | Window word: 0 byte count, 1 status (pops) |
| rd_data | output | 32 | Registered read data |
| fill_level | output | 16 | Number of stored records |
| buf_empty | output | 1 | Queue holds no record |
| buf_full | output | 1 | Queue holds DEPTH records |

## Verification
The queue is filled with no reads until push stalls, which separates correct full detection and back-pressure from overwrite of the oldest record; repeated byte-count reads on the head then show whether word 0 has any side effect. Paired word 0/word 1 drains check order and the status packing, and continued reads past the last record tell a zero-returning empty read from one that wraps or underflows the level. Cycles that push and pop together at mid, empty and full levels expose level arithmetic that counts only one side, and a long random mix with varied push and read densities compares every output against a queue model on each clock.

// File: rtl/dma_rsp_queue_pkg.sv
package dma_rsp_queue_pkg;

  localparam int unsigned BYTES_W = 32;
  localparam int unsigned ERR_W   = 8;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LEVEL_W = 16;

  // Window word select: the status word is the one with the pop side effect.
  localparam logic WORD_BYTES  = 1'b0;
  localparam logic WORD_STATUS = 1'b1;

  typedef struct packed {
    logic [BYTES_W-1:0] bytes;
    logic [ERR_W-1:0]   err;
    logic               early;
  } rsp_rec_t;

  localparam int unsigned REC_W = $bits(rsp_rec_t);

  function automatic logic [WORD_W-1:0] pack_status(input rsp_rec_t rec);
    logic [WORD_W-1:0] w;
    w = '0;
    w[ERR_W-1:0] = rec.err;
    w[ERR_W]     = rec.early;
    return w;
  endfunction

endpackage

// File: rtl/dma_rsp_queue_store.sv
module dma_rsp_queue_store
  import dma_rsp_queue_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = 4
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_ptr,
  input  rsp_rec_t         wr_rec,
  input  logic [PTR_W-1:0] rd_ptr,
  output rsp_rec_t         rd_rec
);

  rsp_rec_t slot_q [DEPTH];

  // One enabled register per slot; storage carries no reset.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_ptr == PTR_W'(gi));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        slot_q[gi] <= wr_rec;
      end
    end
  end

  assign rd_rec = slot_q[rd_ptr];

endmodule

// File: rtl/dma_rsp_queue_ctrl.sv
module dma_rsp_queue_ctrl #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PTR_W = 4,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_acc,
  output logic             pop_acc,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full
);

  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             empty_q, empty_d;
  logic             full_q, full_d;
  logic             state_en;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    push_acc = push_req && !full_q;
    pop_acc  = pop_req && !empty_q;
    state_en = push_acc || pop_acc;

    wr_ptr_d = push_acc ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_acc  ? ptr_inc(rd_ptr_q) : rd_ptr_q;

    count_d = count_q;
    if (push_acc && !pop_acc) begin
      count_d = count_q + CNT_W'(1);
    end else if (pop_acc && !push_acc) begin
      count_d = count_q - CNT_W'(1);
    end

    empty_d = (count_d == '0);
    full_d  = (count_d == DEPTH_CNT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      empty_q  <= 1'b1;
      full_q   <= 1'b0;
    end else if (state_en) begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
      empty_q  <= empty_d;
      full_q   <= full_d;
    end
  end

  assign wr_ptr = wr_ptr_q;
  assign rd_ptr = rd_ptr_q;
  assign count  = count_q;
  assign empty  = empty_q;
  assign full   = full_q;

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= DEPTH_CNT);

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty_q && full_q));

  // R9
  empty_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_q == (count_q == '0));

  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !full_q && !(pop_req && !empty_q)) |=>
      count_q == $past(count_q) + CNT_W'(1));

  // R8
  both_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !full_q && pop_req && !empty_q) |=> $stable(count_q));

endmodule

// File: rtl/dma_rsp_queue_rdport.sv
module dma_rsp_queue_rdport
  import dma_rsp_queue_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_word,
  input  logic              q_empty,
  input  rsp_rec_t          head_rec,
  output logic              pop_req,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] rd_data_q, rd_data_d;

  always_comb begin
    pop_req   = rd_en && (rd_word == WORD_STATUS);
    rd_data_d = '0;
    if (!q_empty) begin
      rd_data_d = (rd_word == WORD_STATUS) ? pack_status(head_rec)
                                           : WORD_W'(head_rec.bytes);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
    end else if (rd_en) begin
      rd_data_q <= rd_data_d;
    end
  end

  assign rd_data = rd_data_q;

  // R6
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && q_empty) |=> rd_data_q == '0);

  // R4
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_word == WORD_STATUS) |=> rd_data_q[WORD_W-1:ERR_W+1] == '0);

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data_q));

endmodule

// File: rtl/dma_rsp_queue.sv
module dma_rsp_queue
  import dma_rsp_queue_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_valid,
  output logic        push_ready,
  input  logic [31:0] push_bytes,
  input  logic [7:0]  push_err,
  input  logic        push_early,
  input  logic        rd_en,
  input  logic        rd_word,
  output logic [31:0] rd_data,
  output logic [15:0] fill_level,
  output logic        buf_empty,
  output logic        buf_full
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             push_acc, pop_acc, pop_req;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             q_empty, q_full;
  rsp_rec_t         wr_rec, head_rec;

  assign wr_rec.bytes = push_bytes;
  assign wr_rec.err   = push_err;
  assign wr_rec.early = push_early;

  dma_rsp_queue_ctrl #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_valid),
    .pop_req  (pop_req),
    .push_acc (push_acc),
    .pop_acc  (pop_acc),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .count    (count),
    .empty    (q_empty),
    .full     (q_full)
  );

  dma_rsp_queue_store #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
  ) u_store (
    .clk    (clk),
    .wr_en  (push_acc),
    .wr_ptr (wr_ptr),
    .wr_rec (wr_rec),
    .rd_ptr (rd_ptr),
    .rd_rec (head_rec)
  );

  dma_rsp_queue_rdport u_rdport (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_word  (rd_word),
    .q_empty  (q_empty),
    .head_rec (head_rec),
    .pop_req  (pop_req),
    .rd_data  (rd_data)
  );

  assign push_ready = !q_full;
  assign fill_level = LEVEL_W'(count);
  assign buf_empty  = q_empty;
  assign buf_full   = q_full;

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && buf_full && !pop_acc) |=> buf_full && fill_level == LEVEL_W'(DEPTH));

  // R3
  peek_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_word == WORD_BYTES && !push_acc) |=> $stable(fill_level));

  // R6
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && buf_empty && !push_valid) |=> fill_level == '0);

endmodule

// File: tb/dma_rsp_queue_bench.sv
module dma_rsp_queue_bench;

  localparam int DEPTH = 16;
  localparam int WATCHDOG_CYCLES = 50000;

  logic        clk;
  logic        rst_n;
  logic        push_valid;
  logic        push_ready;
  logic [31:0] push_bytes;
  logic [7:0]  push_err;
  logic        push_early;
  logic        rd_en;
  logic        rd_word;
  logic [31:0] rd_data;
  logic [15:0] fill_level;
  logic        buf_empty;
  logic        buf_full;

  dma_rsp_queue #(.DEPTH(DEPTH)) u_dma_rsp_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .push_ready (push_ready),
    .push_bytes (push_bytes),
    .push_err   (push_err),
    .push_early (push_early),
    .rd_en      (rd_en),
    .rd_word    (rd_word),
    .rd_data    (rd_data),
    .fill_level (fill_level),
    .buf_empty  (buf_empty),
    .buf_full   (buf_full)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Behavioural reference: queues of byte counts and status words.
  logic [31:0] m_bytes[$];
  logic [31:0] m_stat[$];
  logic [31:0] m_rd;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    int sz;
    sz = m_bytes.size();
    chk({tag, " R3 R4 R10"}, "rd_data", rd_data, m_rd);
    chk({tag, " R9"}, "fill_level", {16'h0, fill_level}, sz);
    chk({tag, " R9"}, "buf_empty", {31'h0, buf_empty}, {31'h0, sz == 0});
    chk({tag, " R9"}, "buf_full", {31'h0, buf_full}, {31'h0, sz == DEPTH});
    chk({tag, " R7"}, "push_ready", {31'h0, push_ready}, {31'h0, sz < DEPTH});
  endtask

  // Drive one cycle at the falling edge, advance the model, check at the next falling edge.
  task automatic step(input string tag, input bit pv, input bit re, input bit rw);
    int sz;
    logic [31:0] b;
    logic [7:0]  e;
    logic        x;
    b = $urandom;
    e = 8'($urandom);
    x = 1'($urandom);
    push_valid = pv;
    push_bytes = b;
    push_err   = e;
    push_early = x;
    rd_en      = re;
    rd_word    = rw;
    sz = m_bytes.size();
    if (re) begin
      if (sz == 0) begin
        m_rd = 32'h0;
      end else if (rw) begin
        m_rd = m_stat[0];
        void'(m_bytes.pop_front());
        void'(m_stat.pop_front());
      end else begin
        m_rd = m_bytes[0];
      end
    end
    if (pv && sz < DEPTH) begin
      m_bytes.push_back(b);
      m_stat.push_back({23'h0, x, e});
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    rst_n      = 1'b0;
    push_valid = 1'b0;
    push_bytes = '0;
    push_err   = '0;
    push_early = 1'b0;
    rd_en      = 1'b0;
    rd_word    = 1'b0;
    m_rd       = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    compare("R1");

    // R2 R5: fill until stall
    for (int i = 0; i < DEPTH; i++) step("R2 R5", 1, 0, 0);
    // R7: pushes against a full queue
    for (int i = 0; i < 4; i++) step("R7", 1, 0, 0);
    // R3: repeated byte-count peeks, then R10 idle holds
    for (int i = 0; i < 3; i++) step("R3", 0, 1, 0);
    for (int i = 0; i < 2; i++) step("R10", 0, 0, 0);
    // R8: push and pop together at full
    step("R8", 1, 1, 1);
    // R4 R5: paired drains
    for (int i = 0; i < DEPTH; i++) begin
      step("R3 R5", 0, 1, 0);
      step("R4 R5", 0, 1, 1);
    end
    // R6: reads on an empty queue, both words
    for (int i = 0; i < 3; i++) step("R6", 0, 1, 1);
    step("R6", 0, 1, 0);
    // R8: push and pop together at empty and mid levels
    step("R8", 1, 1, 1);
    for (int i = 0; i < 5; i++) step("R2", 1, 0, 0);
    for (int i = 0; i < 6; i++) step("R8", 1, 1, 1);

    // Random mix with shifting densities
    for (int ph = 0; ph < 4; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        int pr, rr;
        pr = (ph == 0) ? 80 : (ph == 1) ? 30 : 55;
        rr = (ph == 0) ? 30 : (ph == 1) ? 80 : 55;
        step("R5 R8", ($urandom_range(99) < pr), ($urandom_range(99) < rr),
             1'($urandom));
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule